// File: doc/BRIEF.md
# Ordered Store Buffer with Fence

The block sits between a processor's load/store port and a single-ported memory. Every store the processor issues is taken into a small FIFO in one cycle, so execution can go on while the memory is still busy. The FIFO later writes its entries to memory in the order they arrived, one write per memory handshake. A fence request is held off until the FIFO is empty. Software uses a fence to make sure that data written before a flag is visible before the flag itself.

The `sc_mode` input selects the rule for loads. When it is high (sequential consistency), a load is not taken until every earlier store has been written to memory. Memory accesses then commit strictly in program order. When it is low (relaxed), a load can go past the queued stores. If a queued store matches the load address, the load is served from the youngest matching entry and memory is not read. Otherwise the load is sent to memory ahead of any queued store that has not yet started.

The memory side uses a valid/ready handshake. An access completes in the cycle where `mem_valid` and `mem_ready` are both high. Read data is sampled in that same cycle. A load result comes back as a one-cycle pulse on `rsp_valid`.

Top module: `store_buffer_fence`

## Requirements
- R1: After reset, `sb_empty` is 1, `mem_valid` is 0 and `rsp_valid` is 0.
- R2: A store (`req_op` = 2'b01) is accepted in one cycle while the buffer has room. Buffered stores are written to memory with `mem_write` = 1 in the order they were accepted, one per `mem_valid`/`mem_ready` handshake. The final memory contents reflect that order.
- R3: While the buffer holds DEPTH entries, `req_ready` is 0 for a store. The store is accepted once an entry drains.
- R4: With `sc_mode` = 1, a load (`req_op` = 2'b00) reaches memory only after all stores accepted before it have completed their memory handshakes. Its data reflects those stores.
- R5: With `sc_mode` = 0, a load whose address matches no buffered store is sent to memory before queued stores that have not yet been presented to memory.
- R6: With `sc_mode` = 0, a load whose address matches one or more buffered stores returns the data of the youngest matching store. `rsp_valid` rises in the cycle after acceptance, and no memory read is made.
- R7: A fence (`req_op` bit 1 set) is accepted only when the buffer is empty. No buffered store remains to drain after it.
- R8: A load served by memory raises `rsp_valid` for one cycle, in the cycle after its read handshake, with the read data on `rsp_rdata`.
- R9: Once `mem_valid` is raised, `mem_addr`, `mem_write` and (for writes) `mem_wdata` hold steady until `mem_ready` completes the access.
- R10: `sb_empty` is 0 while any accepted store has not yet completed its memory write, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_mode | input | 1 | 1: sequential-consistency load ordering; 0: relaxed |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 00 load, 01 store, 1x fence |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | One-cycle load result pulse |
| rsp_rdata | output | DW | Load result data |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| sb_empty | output | 1 | No store pending |

## Verification
The hardest situation to reach is a relaxed-mode load that must overtake queued stores. Another is a load that must be served from the youngest of several entries holding the same address. Both require stores to stay in the buffer while the load arrives. The bench reaches them by giving its memory model a long ready latency and issuing the stores back to back, one per cycle. It then issues the load before the first write finishes. The memory model records how many writes had completed when each read happened, and the cycle of each read. These records are used to check ordering in both modes and the response timing.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_FENCE = 2'b10
  } sb_op_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = wr_q + PW'(1);
    if (pop)  rd_d = rd_q + PW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        addr_q[e] <= '0;
        data_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (push && (wr_q == PW'(e))) begin
          addr_q[e] <= push_addr;
          data_q[e] <= push_data;
        end
      end
    end
  end

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign head_addr = addr_q[rd_q];
  assign head_data = data_q[rd_q];

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    logic [PW-1:0] idx;
    hit      = 1'b0;
    hit_data = '0;
    idx      = rd_q;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_q + PW'(k);
      if ((k < int'(cnt_q)) && (addr_q[idx] == look_addr)) begin
        hit      = 1'b1;
        hit_data = data_q[idx];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R2
endmodule

// File: rtl/sb_mem_arb.sv
module sb_mem_arb #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_start,
  input  logic [AW-1:0] ld_addr,
  input  logic          st_avail,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          st_done,
  output logic          ld_done,
  output logic          ld_wait
);
  logic          ld_wait_q, ld_wait_d;
  logic [AW-1:0] ld_addr_q, ld_addr_d;
  logic          st_act_q, st_act_d;
  logic          sel_ld, sel_st;

  // A waiting load wins the port unless a store is already on it.
  assign sel_ld    = ld_wait_q && !st_act_q;
  assign sel_st    = !sel_ld && st_avail;
  assign mem_valid = sel_ld || sel_st;
  assign mem_write = sel_st;
  assign mem_addr  = sel_ld ? ld_addr_q : st_addr;
  assign mem_wdata = st_data;
  assign st_done   = sel_st && mem_ready;
  assign ld_done   = sel_ld && mem_ready;
  assign ld_wait   = ld_wait_q;

  always_comb begin
    ld_wait_d = ld_wait_q;
    ld_addr_d = ld_addr_q;
    if (ld_start) begin
      ld_wait_d = 1'b1;
      ld_addr_d = ld_addr;
    end else if (ld_done) begin
      ld_wait_d = 1'b0;
    end
    st_act_d = sel_st && !mem_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_wait_q <= 1'b0;
      ld_addr_q <= '0;
      st_act_q  <= 1'b0;
    end else begin
      ld_wait_q <= ld_wait_d;
      if (ld_start) ld_addr_q <= ld_addr_d;
      st_act_q  <= st_act_d;
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
      && (!mem_write || $stable(mem_wdata))));  // R9
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_start |-> !ld_wait_q);  // R8
endmodule

// File: rtl/store_buffer_fence.sv
module store_buffer_fence #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sc_mode,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          sb_empty
);
  import sb_pkg::*;

  logic          is_ld, is_st, is_fn, acc;
  logic          push, pop, ld_acc, fwd, ld_start;
  logic          fifo_empty, fifo_full, hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data;
  logic          ld_done, ld_wait;
  logic          rsp_valid_q, rsp_valid_d;
  logic [DW-1:0] rsp_data_q, rsp_data_d;
  logic          sc_load_q, sc_load_d;

  assign is_fn = req_op[1];
  assign is_st = !is_fn && (req_op[0] == OP_STORE[0]);
  assign is_ld = !is_fn && !is_st;

  always_comb begin
    req_ready = 1'b0;
    if (!ld_wait) begin
      if (is_fn)      req_ready = fifo_empty;
      else if (is_st) req_ready = !fifo_full;
      else            req_ready = sc_mode ? fifo_empty : 1'b1;
    end
  end

  assign acc      = req_valid && req_ready;
  assign push     = acc && is_st;
  assign ld_acc   = acc && is_ld;
  assign fwd      = ld_acc && !sc_mode && hit;
  assign ld_start = ld_acc && !fwd;

  sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_addr(req_addr),
    .push_data(req_wdata),
    .pop      (pop),
    .look_addr(req_addr),
    .head_addr(head_addr),
    .head_data(head_data),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .hit      (hit),
    .hit_data (hit_data)
  );

  sb_mem_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_start (ld_start),
    .ld_addr  (req_addr),
    .st_avail (!fifo_empty),
    .st_addr  (head_addr),
    .st_data  (head_data),
    .mem_ready(mem_ready),
    .mem_valid(mem_valid),
    .mem_write(mem_write),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .st_done  (pop),
    .ld_done  (ld_done),
    .ld_wait  (ld_wait)
  );

  always_comb begin
    rsp_valid_d = fwd || ld_done;
    rsp_data_d  = rsp_data_q;
    if (fwd)          rsp_data_d = hit_data;
    else if (ld_done) rsp_data_d = mem_rdata;
    sc_load_d = ld_start ? sc_mode : sc_load_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      sc_load_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rsp_valid_d) rsp_data_q <= rsp_data_d;
      if (ld_start)    sc_load_q  <= sc_load_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign sb_empty  = fifo_empty;

  AST_SC_LOAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && sc_load_q) |-> fifo_empty);  // R4
  AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_fn) |=> !(mem_valid && mem_write));  // R7
  AST_FWD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |=> (rsp_valid && !ld_wait));  // R6
endmodule

// File: tb/store_buffer_fence_test.sv
`timescale 1ns/1ps
module store_buffer_fence_test;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_mode = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_valid, mem_write, sb_empty;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  store_buffer_fence #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .sc_mode(sc_mode),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .sb_empty(sb_empty)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model state and logs
  logic [DW-1:0] mem [256];
  int lat = 0;
  int wcount = 0;
  int rcount = 0;
  logic [AW-1:0] wlog_addr [64];
  logic [DW-1:0] wlog_data [64];
  int rd_wc [64];
  int rd_cyc [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin : mem_model
    bit seen;
    logic [AW-1:0] cap_addr;
    logic cap_write;
    logic [DW-1:0] cap_data;
    int wcnt;
    seen = 1'b0; cap_addr = '0; cap_write = 1'b0; cap_data = '0; wcnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        if (cap_write) begin
          mem[cap_addr] = cap_data;
          if (wcount < 64) begin
            wlog_addr[wcount] = cap_addr;
            wlog_data[wcount] = cap_data;
          end
          wcount++;
        end else begin
          if (rcount < 64) begin
            rd_wc[rcount] = wcount;
            rd_cyc[rcount] = cyc;
          end
          rcount++;
        end
        mem_ready = 1'b0;
        seen = 1'b0;
      end else if (mem_valid) begin
        if (!seen) begin
          seen = 1'b1; cap_addr = mem_addr; cap_write = mem_write; cap_data = mem_wdata; wcnt = 0;
        end else if (mem_addr != cap_addr || mem_write != cap_write ||
                     (cap_write && mem_wdata != cap_data)) begin
          chk(1'b0, "R9 request changed before ready", int'(mem_addr), int'(cap_addr));
        end
        if (wcnt >= lat) begin
          mem_ready = 1'b1;
          mem_rdata = mem[cap_addr];
        end else begin
          wcnt++;
        end
      end
    end
  end

  // issue a request and return after it has been accepted (at a negedge)
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, output logic [DW-1:0] data,
                         output int waited, output int at_cyc);
    issue(2'b00, a, '0);
    waited = 0;
    while (!rsp_valid && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    data = rsp_rdata;
    at_cyc = cyc;
  endtask

  task automatic t_reset;
    chk(sb_empty == 1'b1, "R1 sb_empty after reset", int'(sb_empty), 1);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", int'(mem_valid), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_fifo_order;
    int base;
    base = wcount; sc_mode = 1'b0; lat = 2;
    for (int i = 0; i < 4; i++) issue(2'b01, AW'(8'h60 + i), DW'(16'h6000 + i));
    issue(2'b10, '0, '0);
    chk(wcount - base == 4, "R7 writes done at fence acceptance", wcount - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk(wlog_addr[base + i] == AW'(8'h60 + i), "R2 drain address order",
          int'(wlog_addr[base + i]), 8'h60 + i);
      chk(wlog_data[base + i] == DW'(16'h6000 + i), "R2 drain data order",
          int'(wlog_data[base + i]), 16'h6000 + i);
    end
  endtask

  task automatic t_full;
    int base;
    base = wcount; sc_mode = 1'b0; lat = 10;
    for (int i = 0; i < 4; i++) issue(2'b01, AW'(8'h70 + i), DW'(16'h7000 + i));
    req_valid = 1'b1; req_op = 2'b01; req_addr = 8'h74; req_wdata = 16'h7004;
    #1;
    chk(req_ready == 1'b0, "R3 store stalled when full", int'(req_ready), 0);
    chk(sb_empty == 1'b0, "R10 sb_empty low with pending stores", int'(sb_empty), 0);
    req_valid = 1'b0;
    issue(2'b01, 8'h74, 16'h7004);
    chk(wcount - base >= 1, "R3 stalled store accepted after drain", wcount - base, 1);
    issue(2'b10, '0, '0);
    chk(sb_empty == 1'b1, "R10 sb_empty high after fence", int'(sb_empty), 1);
    chk(mem[8'h74] == 16'h7004, "R3 stalled store reached memory", int'(mem[8'h74]), 16'h7004);
  endtask

  task automatic t_sc_load;
    int base, rb, w, c;
    logic [DW-1:0] d;
    base = wcount; sc_mode = 1'b1; lat = 3;
    issue(2'b01, 8'h10, 16'h1111);
    issue(2'b01, 8'h11, 16'h2222);
    rb = rcount;
    do_load(8'h20, d, w, c);
    chk(rd_wc[rb] - base == 2, "R4 read after all earlier writes", rd_wc[rb] - base, 2);
    chk(d == 16'hA020, "R8 load data from memory", int'(d), 16'hA020);
    chk(c == rd_cyc[rb], "R8 response one cycle after read handshake", c, rd_cyc[rb]);
    rb = rcount;
    issue(2'b01, 8'h10, 16'h3333);
    do_load(8'h10, d, w, c);
    chk(d == 16'h3333, "R4 load sees earlier store via memory", int'(d), 16'h3333);
    chk(rcount - rb == 1, "R4 load went to memory", rcount - rb, 1);
  endtask

  task automatic t_bypass;
    int base, rb, w, c;
    logic [DW-1:0] d;
    base = wcount; sc_mode = 1'b0; lat = 4;
    for (int i = 0; i < 3; i++) issue(2'b01, AW'(8'h30 + i), DW'(16'h3000 + i));
    rb = rcount;
    do_load(8'h40, d, w, c);
    chk(rd_wc[rb] - base < 3, "R5 load bypassed queued stores", rd_wc[rb] - base, 1);
    chk(d == 16'hA040, "R5 bypass load data", int'(d), 16'hA040);
    issue(2'b10, '0, '0);
    chk(mem[8'h32] == 16'h3002, "R2 bypassed stores still written", int'(mem[8'h32]), 16'h3002);
  endtask

  task automatic t_forward;
    int rb, w, c;
    logic [DW-1:0] d;
    sc_mode = 1'b0; lat = 6;
    issue(2'b01, 8'h50, 16'h5A5A);
    issue(2'b01, 8'h51, 16'h5B5B);
    issue(2'b01, 8'h50, 16'h5C5C);
    rb = rcount;
    do_load(8'h50, d, w, c);
    chk(d == 16'h5C5C, "R6 forwarded from youngest entry", int'(d), 16'h5C5C);
    chk(w == 0, "R6 response in cycle after acceptance", w, 0);
    chk(rcount == rb, "R6 no memory read on forward", rcount - rb, 0);
    issue(2'b10, '0, '0);
    chk(mem[8'h50] == 16'h5C5C, "R2 younger store lands last", int'(mem[8'h50]), 16'h5C5C);
  endtask

  task automatic t_fence;
    int base;
    base = wcount; sc_mode = 1'b0; lat = 3;
    issue(2'b01, 8'h80, 16'h8080);
    issue(2'b01, 8'h81, 16'h8181);
    chk(sb_empty == 1'b0, "R10 pending before fence", int'(sb_empty), 0);
    issue(2'b10, '0, '0);
    chk(wcount - base == 2, "R7 fence waits for drain", wcount - base, 2);
    chk(sb_empty == 1'b1, "R7 buffer empty after fence", int'(sb_empty), 1);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo_order();
    t_full();
    t_sc_load();
    t_bypass();
    t_forward();
    t_fence();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule